// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each beat of a four-word burst in a pipelined synchronous memory. A command with the load strobe low, while the device is selected, captures an external start address and presents it as the first beat. Each later command with the strobe high steps a two-bit beat counter. The low two address bits of every beat are derived from the captured start address. The upper bits stay at their loaded value for the whole burst.

Two beat orders are available. The first is a wrapping increment of the start's low bits. The second is an exclusive-OR of the start's low bits with the beat count. The order select is not registered, so a change shows on the address output without waiting for a clock edge. A stall input freezes all state. A load command issued while the device is not selected ends the current burst. The memory array and the data path sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_valid` is 0 and `addr` is all zeros.
- R2: On an edge with `stall`=0, `load_n`=0 and `sel`=1, the block captures `base_addr`. From the following cycle, `addr` equals that value and `addr_valid` is 1. This also applies when a burst is already running, and the new burst starts again at beat 0.
- R3: With `interleave`=0, each advance edge (`stall`=0, `load_n`=1, burst active) makes the low two address bits equal to (start + beat) mod 4. For a start of 2 the beats are 2, 3, 0, 1.
- R4: With `interleave`=1, the low two bits equal start XOR beat. For a start of 1 the beats are 1, 0, 3, 2, and for a start of 2 they are 2, 3, 0, 1.
- R5: `interleave` acts without a clock. After a change, `addr` shows the order it selects for the current beat count within the same cycle.
- R6: Advances after the fourth beat wrap around inside the same four-word group. `addr[AW-1:2]` never changes while a burst advances.
- R7: An edge with `stall`=0, `load_n`=0 and `sel`=0 ends the burst. `addr_valid` is 0 from the next cycle, and later advances leave it at 0.
- R8: An advance edge while no burst is active gives `addr_valid`=0.
- R9: While `stall`=1, the clock has no effect. `addr_valid` and the beat state hold, so `addr` holds as long as `interleave` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | 1 freezes all state on the edge |
| sel | input | 1 | Device selected (combined chip enables) |
| load_n | input | 1 | 0 = load/deselect command, 1 = advance |
| interleave | input | 1 | Beat order: 0 linear, 1 XOR |
| base_addr | input | AW | External start address |
| addr | output | AW | Current beat address |
| addr_valid | output | 1 | Current address belongs to an active burst |

## Verification
The order assertions assume that `interleave` does not change between the two cycles they compare. The stall hold check only compares `addr` when `interleave` was stable, because a mode change during a stall still reaches the output. The random stimulus draws the mode as a slow signal: it changes rarely and only at the falling edge, before the next command. Commands are drawn with a bias toward advances, so that bursts run long enough to wrap, and with occasional stalls and deselects.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          sel,
  input  logic          load_n,
  input  logic          interleave,
  input  logic [AW-1:0] base_addr,
  output logic [AW-1:0] addr,
  output logic          addr_valid
);
  localparam int LOW_W = 2;

  logic [AW-1:0]    start_q;
  logic [LOW_W-1:0] beat_q;
  logic             active_q;
  logic             valid_q;
  logic [LOW_W-1:0] low_bits;

  wire take    = !stall;
  wire do_load = take && !load_n && sel;
  wire do_stop = take && !load_n && !sel;
  wire do_adv  = take && load_n && active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
      valid_q  <= 1'b0;
    end else if (do_load) begin
      start_q  <= base_addr;
      beat_q   <= '0;
      active_q <= 1'b1;
      valid_q  <= 1'b1;
    end else if (do_stop) begin
      active_q <= 1'b0;
      valid_q  <= 1'b0;
    end else if (do_adv) begin
      beat_q   <= beat_q + 1'b1;
      valid_q  <= 1'b1;
    end else if (take) begin
      valid_q  <= 1'b0;
    end
  end

  assign low_bits   = interleave ? (start_q[LOW_W-1:0] ^ beat_q)
                                 : (start_q[LOW_W-1:0] + beat_q);
  assign addr       = {start_q[AW-1:LOW_W], low_bits};
  assign addr_valid = valid_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          sel,
  input logic          load_n,
  input logic          interleave,
  input logic [AW-1:0] base_addr,
  input logic [AW-1:0] addr,
  input logic          addr_valid
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !load_n && sel) |=> (addr_valid && addr == $past(base_addr)));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && load_n && addr_valid && !interleave) |=>
      (interleave || addr[1:0] == 2'($past(addr[1:0]) + 2'd1)));

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && load_n && addr_valid) |=>
      (addr_valid && addr[AW-1:2] == $past(addr[AW-1:2])));

  // R7
  deselect_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !load_n && !sel) |=> !addr_valid);

  // R8
  idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && load_n && !addr_valid) |=> !addr_valid);

  // R9
  stall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(addr_valid));

  // R9
  stall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!$stable(interleave) || $stable(addr)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .stall(stall), .sel(sel), .load_n(load_n),
  .interleave(interleave), .base_addr(base_addr), .addr(addr),
  .addr_valid(addr_valid)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 19;

  logic clk = 1'b0;
  logic rst_n, stall, sel, load_n, interleave;
  logic [AW-1:0] base_addr, addr;
  logic addr_valid;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_start;
  logic [1:0]    m_beat;
  logic          m_active, m_valid;

  always #5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sel(sel), .load_n(load_n),
    .interleave(interleave), .base_addr(base_addr), .addr(addr),
    .addr_valid(addr_valid)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, logic [1:0] b, logic m);
    logic [1:0] lo;
    lo = m ? (s[1:0] ^ b) : 2'(s[1:0] + b);
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] ea, logic ev);
    checks++;
    if (addr !== ea || addr_valid !== ev) begin
      errors++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
               req, addr, addr_valid, ea, ev);
    end
  endtask

  task automatic check_model(string req);
    if (m_valid) check(req, exp_addr(m_start, m_beat, interleave), 1'b1);
    else begin
      checks++;
      if (addr_valid !== 1'b0) begin
        errors++;
        $display("FAIL %s: valid=%b expected valid=0", req, addr_valid);
      end
    end
  endtask

  task automatic step(logic st, logic sl, logic ld_n, logic [AW-1:0] ba);
    stall = st; sel = sl; load_n = ld_n; base_addr = ba;
    @(posedge clk);
    if (!st) begin
      if (!ld_n && sl) begin m_start = ba; m_beat = 2'd0; m_active = 1'b1; m_valid = 1'b1; end
      else if (!ld_n) begin m_active = 1'b0; m_valid = 1'b0; end
      else if (m_active) begin m_beat = m_beat + 2'd1; m_valid = 1'b1; end
      else m_valid = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] hold_a;
    void'($urandom(32'd4711));
    rst_n = 1'b0; stall = 1'b0; sel = 1'b0; load_n = 1'b1; interleave = 1'b0;
    base_addr = '0;
    m_start = '0; m_beat = 2'd0; m_active = 1'b0; m_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", '0, 1'b0);

    // R8 advance with nothing loaded
    step(1'b0, 1'b1, 1'b1, 19'h1234);
    check("R8", '0, 1'b0);

    // R2 + R3 linear from start 2
    interleave = 1'b0;
    step(1'b0, 1'b1, 1'b0, 19'h5A5A6);
    check("R2", 19'h5A5A6, 1'b1);
    step(1'b0, 1'b1, 1'b1, '0); check("R3", 19'h5A5A7, 1'b1);
    step(1'b0, 1'b1, 1'b1, '0); check("R3", 19'h5A5A4, 1'b1);
    step(1'b0, 1'b1, 1'b1, '0); check("R3", 19'h5A5A5, 1'b1);
    // R6 wrap back to the start
    step(1'b0, 1'b1, 1'b1, '0); check("R6", 19'h5A5A6, 1'b1);

    // R4 interleaved from start 1
    interleave = 1'b1;
    step(1'b0, 1'b1, 1'b0, 19'h0F0F1);
    check("R4", 19'h0F0F1, 1'b1);
    step(1'b0, 1'b1, 1'b1, '0); check("R4", 19'h0F0F0, 1'b1);
    step(1'b0, 1'b1, 1'b1, '0); check("R4", 19'h0F0F3, 1'b1);
    step(1'b0, 1'b1, 1'b1, '0); check("R4", 19'h0F0F2, 1'b1);

    // R5 mode change without clock: beat 3, start 1 -> linear gives 0
    interleave = 1'b0;
    #1;
    check("R5", 19'h0F0F0, 1'b1);
    interleave = 1'b1;
    #1;
    check("R5", 19'h0F0F2, 1'b1);

    // R9 stall freezes beat and valid
    hold_a = addr;
    step(1'b1, 1'b1, 1'b1, '0); check("R9", hold_a, 1'b1);
    step(1'b1, 1'b1, 1'b0, 19'h7FFFF); check("R9", hold_a, 1'b1);
    step(1'b0, 1'b1, 1'b1, '0); check("R9", 19'h0F0F1, 1'b1);

    // R2 restart mid-burst
    step(1'b0, 1'b1, 1'b1, '0);
    step(1'b0, 1'b1, 1'b0, 19'h33332);
    check("R2", 19'h33332, 1'b1);

    // R7 deselect ends the burst, advances stay invalid
    step(1'b0, 1'b0, 1'b0, 19'h11111);
    check_model("R7");
    step(1'b0, 1'b1, 1'b1, '0); check_model("R7");
    step(1'b0, 1'b0, 1'b1, '0); check_model("R7");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 19) == 0) interleave = ~interleave;
      if (r < 10) step(1'b1, 1'($urandom), 1'($urandom), AW'($urandom));
      else if (r < 22) step(1'b0, 1'b1, 1'b0, AW'($urandom));
      else if (r < 26) step(1'b0, 1'b0, 1'b0, AW'($urandom));
      else step(1'b0, 1'($urandom), 1'b1, AW'($urandom));
      check_model(interleave ? "R4" : "R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule